// File: doc/BRIEF.md
# Oscillator coarse tuning sequencer

This controller brings a digitally tuned oscillator near a requested channel by fixing its coarse control codes one group at a time. A single wide-range select bit is set first, a 10-bit capacitor-bank code follows, and a 20-bit thermometer code for the narrow range comes last. Each decision rests on one verdict from an external frequency-compare unit. That unit signals a verdict with `meas_valid` for one cycle, and `meas_up` high means the oscillator runs below the target.

Only the codes of the active stage move. When the narrow search ends, the block pulses `done` to hand over to the gain tuning that follows, and it then holds every code. A synchronous `start` restarts the whole sequence from the default codes at any time.

Top module: `osc_coarse_seq`

## Requirements
- R1: After reset the outputs are: `stage` = 0, `wide_sel` = 0, `cap_code` = 10'b1000000000, `nar_code` with its ten low bits set, and `done` = 0. The `stage` encoding is 0 idle, 1 wide, 2 capacitor, 3 narrow.
- R2: When `start` is high at a clock edge, the next cycle shows the default codes of R1 and `stage` = 1. This holds from every stage, and `start` takes priority over a verdict given in the same cycle.
- R3: In stage 1, a verdict copies `meas_up` into `wide_sel` and moves to stage 2.
- R4: In stage 2 the capacitor code is resolved MSB first, over ten verdicts, from bit 9 down to bit 0. On a DOWN verdict the bit under test is cleared, and on an UP verdict it stays set. The next lower bit is then set as the new trial. After the verdict for bit 0 the block moves to stage 3. If every verdict is UP exactly when the code is below T, the final code is T-1 for T ≥ 1, and 0 for T = 0.
- R5: `nar_code` always holds a count of ones packed from bit 0, with a count of 10 at entry. In stage 3 each verdict adds one bit (UP) or removes one bit (DOWN).
- R6: Stage 3 ends without changing the code in two cases. The first is a verdict opposite to the previous step. The second is a step that would go above 20 ones or below 0 ones.
- R7: Codes that belong to a stage other than the active one do not change, except on `start`.
- R8: `done` is high for exactly one cycle, in the cycle after the verdict that ends stage 3, and `stage` returns to 0 at the same time.
- R9: In stage 0 without `start`, `meas_valid` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Restart the tuning sequence |
| meas_valid | input | 1 | Compare verdict present this cycle |
| meas_up | input | 1 | Verdict: 1 means the oscillator is below target |
| stage | output | 2 | Active stage (0 idle, 1 wide, 2 capacitor, 3 narrow) |
| wide_sel | output | 1 | Wide-range select bit |
| cap_code | output | CAP_W | Capacitor-bank code |
| nar_code | output | NAR_W | Narrow-range thermometer code |
| done | output | 1 | One-cycle hand-over pulse |

## Verification
The bench uses the default widths: 10 capacitor bits, 20 narrow bits, and a narrow mid value of 10. With these widths the narrow search can reach both ends, 0 ones and 20 ones, in a few verdicts, and the capacitor search can reach its extreme codes 0 and 1023. The bench varies the gap between verdicts and includes a restart in the middle of a run. This shows that the codes move only on verdicts and that `start` overrides them.

// File: rtl/osc_coarse_seq.sv
module osc_coarse_seq #(
  parameter int CAP_W   = 10,
  parameter int NAR_W   = 20,
  parameter int NAR_MID = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             meas_valid,
  input  logic             meas_up,
  output logic [1:0]       stage,
  output logic             wide_sel,
  output logic [CAP_W-1:0] cap_code,
  output logic [NAR_W-1:0] nar_code,
  output logic             done
);
  localparam int IW = $clog2(CAP_W);
  localparam int CW = $clog2(NAR_W + 1);
  localparam logic [1:0] S_IDLE = 2'd0, S_WIDE = 2'd1, S_CAP = 2'd2, S_NAR = 2'd3;
  localparam logic [CAP_W-1:0] CAP_INIT = {1'b1, {(CAP_W-1){1'b0}}};
  localparam logic [CW-1:0] CNT_MAX = CW'(NAR_W);
  localparam logic [CW-1:0] CNT_MID = CW'(NAR_MID);

  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;
  logic          dir, first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage    <= S_IDLE;
      wide_sel <= 1'b0;
      cap_code <= CAP_INIT;
      idx      <= IW'(CAP_W - 1);
      cnt      <= CNT_MID;
      dir      <= 1'b0;
      first    <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        stage    <= S_WIDE;
        wide_sel <= 1'b0;
        cap_code <= CAP_INIT;
        idx      <= IW'(CAP_W - 1);
        cnt      <= CNT_MID;
        first    <= 1'b1;
      end else if (meas_valid) begin
        case (stage)
          S_WIDE: begin
            wide_sel <= meas_up;
            stage    <= S_CAP;
          end
          S_CAP: begin
            if (!meas_up) cap_code[idx] <= 1'b0;
            if (idx == '0) stage <= S_NAR;
            else begin
              cap_code[idx - 1'b1] <= 1'b1;
              idx <= idx - 1'b1;
            end
          end
          S_NAR: begin
            if ((!first && meas_up != dir) || (meas_up && cnt == CNT_MAX) ||
                (!meas_up && cnt == '0)) begin
              stage <= S_IDLE;
              done  <= 1'b1;
            end else begin
              cnt   <= meas_up ? cnt + 1'b1 : cnt - 1'b1;
              dir   <= meas_up;
              first <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb
    for (int i = 0; i < NAR_W; i++) nar_code[i] = CW'(i) < cnt;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_WIDE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (stage != S_WIDE && !start) |=> $stable(wide_sel)); // R7
  AST_CAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (stage != S_CAP && !start) |=> $stable(cap_code)); // R7
  AST_NAR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (stage != S_NAR && !start) |=> $stable(nar_code)); // R7
  AST_NAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == S_NAR && !start) |=> $countones(nar_code ^ $past(nar_code)) <= 1); // R5
  AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == S_IDLE && !start) |=> stage == S_IDLE); // R9
endmodule

// File: tb/sim_osc_coarse_seq.sv
module sim_osc_coarse_seq;
  logic clk = 0, rst_n = 0, start = 0, meas_valid = 0, meas_up = 0;
  logic [1:0] stage;
  logic wide_sel, done;
  logic [9:0] cap_code;
  logic [19:0] nar_code;
  int checks = 0, fails = 0, cyc = 0;
  int m_stg, m_wide, m_cap, m_idx, m_n, m_dir, m_first, m_done;

  always #5 clk = ~clk;

  osc_coarse_seq u0 (.clk(clk), .rst_n(rst_n), .start(start), .meas_valid(meas_valid),
    .meas_up(meas_up), .stage(stage), .wide_sel(wide_sel), .cap_code(cap_code),
    .nar_code(nar_code), .done(done));

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", r, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    m_done = 0;
    if (!rst_n) begin
      m_stg = 0; m_wide = 0; m_cap = 512; m_idx = 9; m_n = 10; m_first = 1; m_dir = 0;
    end else if (start) begin
      m_stg = 1; m_wide = 0; m_cap = 512; m_idx = 9; m_n = 10; m_first = 1;
    end else if (meas_valid) begin
      if (m_stg == 1) begin m_wide = meas_up; m_stg = 2; end
      else if (m_stg == 2) begin
        if (!meas_up) m_cap -= (1 << m_idx);
        if (m_idx == 0) m_stg = 3;
        else begin m_idx--; m_cap += (1 << m_idx); end
      end else if (m_stg == 3) begin
        if ((!m_first && meas_up != m_dir) || (meas_up && m_n == 20) || (!meas_up && m_n == 0)) begin
          m_stg = 0; m_done = 1;
        end else begin
          m_n += meas_up ? 1 : -1; m_dir = meas_up; m_first = 0;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R2 stage", stage, m_stg);
    chk("R3 wide_sel", wide_sel, m_wide);
    chk("R4 cap_code", cap_code, m_cap);
    chk("R5 nar_code", nar_code, (1 << m_n) - 1);
    chk("R8 done", done, m_done);
  end

  always @(posedge clk) if (cyc > 150000) begin
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic pulse_start();
    @(negedge clk); start = 1; @(negedge clk); start = 0;
  endtask

  task automatic verdict(input int wup, input int capT, input int narT, input int gap);
    for (int k = 0; k < gap; k++) @(negedge clk);
    meas_valid = 1;
    meas_up = (m_stg == 1) ? wup[0] : (m_stg == 2) ? (m_cap < capT) : (m_n < narT);
    @(negedge clk); meas_valid = 0;
  endtask

  task automatic run(input int wup, input int capT, input int narT, input int gap,
                     input int exp_cap, input int exp_n);
    pulse_start();
    chk("R2 start enters wide", stage, 1);
    for (int t = 0; t < 60 && m_stg != 0; t++) begin
      verdict(wup, capT, narT, gap);
      if (m_stg == 0) chk("R8 done after last verdict", done, 1);
    end
    chk("R3 wide chosen and held (R7)", wide_sel, wup);
    chk("R4 final cap", cap_code, exp_cap);
    chk("R6 final narrow", nar_code, (1 << exp_n) - 1);
    @(negedge clk);
    chk("R8 done single cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 stage", stage, 0);
    chk("R1 wide", wide_sel, 0);
    chk("R1 cap", cap_code, 512);
    chk("R1 narrow", nar_code, 1023);
    chk("R1 done", done, 0);
    rst_n = 1;
    @(negedge clk);
    run(1, 600, 15, 0, 599, 15);
    run(0, 1, 3, 2, 0, 2);
    run(1, 1024, 25, 1, 1023, 20);
    run(0, 0, 0, 3, 0, 0);
    run(1, 342, 10, 0, 341, 9);
    pulse_start();
    verdict(1, 100, 5, 0);
    verdict(1, 100, 5, 1);
    verdict(1, 100, 5, 0);
    pulse_start();
    chk("R2 restart cap default", cap_code, 512);
    chk("R2 restart wide default", wide_sel, 0);
    for (int t = 0; t < 60 && m_stg != 0; t++) verdict(0, 777, 12, 1);
    chk("R4 after restart", cap_code, 776);
    chk("R6 after restart", nar_code, (1 << 12) - 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); meas_valid = 1; meas_up = k[0];
    end
    @(negedge clk); meas_valid = 0;
    chk("R9 idle stage", stage, 0);
    chk("R9 idle cap", cap_code, 776);
    chk("R9 idle narrow", nar_code, (1 << 12) - 1);
    @(negedge clk); start = 1; meas_valid = 1; meas_up = 1;
    @(negedge clk); start = 0; meas_valid = 0;
    chk("R2 start over verdict", stage, 1);
    chk("R2 start over verdict wide", wide_sel, 0);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule